// File: doc/BRIEF.md
# Serial Port Request Arbiter

This block decides which request a serial port raises, and at what priority. Three conditions can need service:

- the receiver holds a character (receive ready);
- the transmit buffer is empty;
- the transmit shift register is empty.

Each direction has its own DMA mask bit. When the bit is set, the condition asks the DMA engine for a transfer. When it is clear, the condition asks the CPU for an interrupt.

Each direction also has a transaction counter that software loads. Every acknowledged DMA transfer for that direction decrements the counter. When the counter reaches zero, hardware clears that direction's DMA mask and latches an end-of-block flag. The flag then requests an interrupt for the same direction until software clears it.

Only one request is presented at a time. It comes with a 2-bit source identifier and the programmed 3-bit level, and it stays up until it is acknowledged. The internal order between sources is fixed. The level only places the whole port against other requesters. Level 7 silences the port.

Top module: `sci_req_arbiter`

## Requirements
- R1: After reset `req_valid`, both DMA masks and both end-of-block flags are 0, the counters are 0, and `req_level` reads 7.
- R2: With `rx_dma_mask`=1, `rx_ready` requests source id 0 (receive DMA). With `rx_dma_mask`=0 it requests id 2 (receive interrupt).
- R3: With `tx_dma_mask`=1, either `tx_buf_empty` or `tx_shift_empty` requests id 1 (transmit DMA). With the mask at 0 it requests id 3 (transmit interrupt).
- R4: When several sources are pending, the lowest id wins, so the order is 0, 1, 2, 3.
- R5: `req_level` shows the programmed level. While the level register holds 7, `req_valid` is 0 from the next clock edge on.
- R6: A request is registered only while `req_valid` is 0. It keeps the same id until `req_ack` is seen with it, and it drops on the following edge. The next request can appear one edge after that.
- R7: An acknowledged request with id 0 or 1 decrements that direction's nonzero counter. If the counter goes from 1 to 0, the same edge clears that direction's DMA mask and sets its end-of-block flag. A counter that is already 0 is left unchanged.
- R8: An end-of-block flag raises its direction's interrupt request (id 2 for receive, id 3 for transmit) until its clear strobe. When set and clear occur in the same cycle, set wins.
- R9: A configuration write (`cfg_we`) overrides a hardware mask clear in the same cycle. A counter load overrides that direction's decrement, and in that cycle it also suppresses that direction's mask clear and end-of-block set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_ready | input | 1 | Receiver has a character |
| tx_buf_empty | input | 1 | Transmit buffer empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| cfg_we | input | 1 | Write masks and level |
| cfg_rx_dma | input | 1 | Receive DMA mask value to write |
| cfg_tx_dma | input | 1 | Transmit DMA mask value to write |
| cfg_level | input | 3 | Priority level to write (0 highest, 7 off) |
| rx_cnt_we | input | 1 | Load receive counter |
| tx_cnt_we | input | 1 | Load transmit counter |
| cnt_wdata | input | CNT_W | Counter load value |
| rx_eob_clr | input | 1 | Clear receive end-of-block flag |
| tx_eob_clr | input | 1 | Clear transmit end-of-block flag |
| req_ack | input | 1 | Acknowledge of the presented request |
| req_valid | output | 1 | Request presented |
| req_id | output | 2 | Winning source: 0 rx DMA, 1 tx DMA, 2 rx irq, 3 tx irq |
| req_level | output | 3 | Programmed priority level |
| rx_dma_mask | output | 1 | Receive DMA mask |
| tx_dma_mask | output | 1 | Transmit DMA mask |
| rx_eob | output | 1 | Receive end-of-block flag |
| tx_eob | output | 1 | Transmit end-of-block flag |

## Verification
Directed phases come first:

- A receive-only stream runs with a short counter, so the id must switch from 0 to 2 exactly when the counter empties.
- All sources are raised together under both mask settings, which separates a correct fixed order from a rotating or reversed one.
- Stretches with no acknowledge show whether requests are held and stable.
- Writes timed onto the ack edge check which update wins.

A long random phase then mixes sources, acknowledges, configuration writes, counter loads and flag clears. The outputs are compared against a behavioural model on every cycle.

// File: rtl/sci_req_arbiter.sv
module sci_req_arbiter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_ready,
  input  logic             tx_buf_empty,
  input  logic             tx_shift_empty,
  input  logic             cfg_we,
  input  logic             cfg_rx_dma,
  input  logic             cfg_tx_dma,
  input  logic [2:0]       cfg_level,
  input  logic             rx_cnt_we,
  input  logic             tx_cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             rx_eob_clr,
  input  logic             tx_eob_clr,
  input  logic             req_ack,
  output logic             req_valid,
  output logic [1:0]       req_id,
  output logic [2:0]       req_level,
  output logic             rx_dma_mask,
  output logic             tx_dma_mask,
  output logic             rx_eob,
  output logic             tx_eob
);
  localparam logic [1:0] ID_RXD = 2'd0, ID_TXD = 2'd1, ID_RXI = 2'd2, ID_TXI = 2'd3;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [2:0] LVL_OFF = 3'd7;

  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic [2:0]       lvl;
  logic [3:0]       pend;
  logic [1:0]       win;

  wire tx_src   = tx_buf_empty | tx_shift_empty;
  wire ack_fire = req_valid & req_ack;
  wire rx_hit   = ack_fire & (req_id == ID_RXD) & (rx_cnt != '0) & ~rx_cnt_we;
  wire tx_hit   = ack_fire & (req_id == ID_TXD) & (tx_cnt != '0) & ~tx_cnt_we;
  wire rx_done  = rx_hit & (rx_cnt == ONE);
  wire tx_done  = tx_hit & (tx_cnt == ONE);

  assign pend = {(tx_src & ~tx_dma_mask) | tx_eob,
                 (rx_ready & ~rx_dma_mask) | rx_eob,
                 tx_src & tx_dma_mask,
                 rx_ready & rx_dma_mask};
  assign req_level = lvl;

  always_comb begin
    if (pend[0])      win = ID_RXD;
    else if (pend[1]) win = ID_TXD;
    else if (pend[2]) win = ID_RXI;
    else              win = ID_TXI;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt <= '0;
      tx_cnt <= '0;
    end else begin
      if (rx_cnt_we)   rx_cnt <= cnt_wdata;
      else if (rx_hit) rx_cnt <= rx_cnt - ONE;
      if (tx_cnt_we)   tx_cnt <= cnt_wdata;
      else if (tx_hit) tx_cnt <= tx_cnt - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_dma_mask <= 1'b0;
      tx_dma_mask <= 1'b0;
      lvl         <= LVL_OFF;
      rx_eob      <= 1'b0;
      tx_eob      <= 1'b0;
    end else begin
      if (cfg_we) begin
        rx_dma_mask <= cfg_rx_dma;
        tx_dma_mask <= cfg_tx_dma;
        lvl         <= cfg_level;
      end else begin
        if (rx_done) rx_dma_mask <= 1'b0;
        if (tx_done) tx_dma_mask <= 1'b0;
      end
      if (rx_done)         rx_eob <= 1'b1;
      else if (rx_eob_clr) rx_eob <= 1'b0;
      if (tx_done)         tx_eob <= 1'b1;
      else if (tx_eob_clr) tx_eob <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_id    <= ID_RXD;
    end else if (lvl == LVL_OFF || ack_fire) begin
      req_valid <= 1'b0;
    end else if (!req_valid && |pend) begin
      req_valid <= 1'b1;
      req_id    <= win;
    end
  end

  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack && lvl != LVL_OFF) |=> (req_valid && $stable(req_id)));
  a_r6_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack) |=> !req_valid);
  a_r5_level7_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_level == LVL_OFF) |=> !req_valid);
  a_r7_rx_block_end: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack && req_id == ID_RXD && rx_cnt == ONE && !rx_cnt_we && !cfg_we)
    |=> (!rx_dma_mask && rx_eob));
  a_r7_tx_block_end: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack && req_id == ID_TXD && tx_cnt == ONE && !tx_cnt_we && !cfg_we)
    |=> (!tx_dma_mask && tx_eob));
  a_r8_eob_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eob && !rx_eob_clr) |=> rx_eob);
endmodule

// File: tb/tb_sci_req_arbiter.sv
module tb_sci_req_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_ready = 0, tx_buf_empty = 0, tx_shift_empty = 0;
  logic cfg_we = 0, cfg_rx_dma = 0, cfg_tx_dma = 0;
  logic [2:0] cfg_level = 3'd7;
  logic rx_cnt_we = 0, tx_cnt_we = 0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic rx_eob_clr = 0, tx_eob_clr = 0;
  logic req_ack = 0;
  logic req_valid;
  logic [1:0] req_id;
  logic [2:0] req_level;
  logic rx_dma_mask, tx_dma_mask, rx_eob, tx_eob;

  sci_req_arbiter #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_buf_empty(tx_buf_empty),
    .tx_shift_empty(tx_shift_empty), .cfg_we(cfg_we), .cfg_rx_dma(cfg_rx_dma),
    .cfg_tx_dma(cfg_tx_dma), .cfg_level(cfg_level), .rx_cnt_we(rx_cnt_we),
    .tx_cnt_we(tx_cnt_we), .cnt_wdata(cnt_wdata), .rx_eob_clr(rx_eob_clr),
    .tx_eob_clr(tx_eob_clr), .req_ack(req_ack), .req_valid(req_valid),
    .req_id(req_id), .req_level(req_level), .rx_dma_mask(rx_dma_mask),
    .tx_dma_mask(tx_dma_mask), .rx_eob(rx_eob), .tx_eob(tx_eob));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int ack_mode = 0;
  bit run_cmp = 0;

  // behavioural reference state
  int m_rxm, m_txm, m_lvl, m_rxc, m_txc, m_rxe, m_txe, m_req, m_id;

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, got, exp);
    end
  endtask

  always @(posedge clk) begin
    int ts, cand, fire, rxz, txz, rxd, txd;
    cyc++;
    if (!rst_n) begin
      m_rxm = 0; m_txm = 0; m_lvl = 7; m_rxc = 0; m_txc = 0;
      m_rxe = 0; m_txe = 0; m_req = 0; m_id = 0;
    end else begin
      ts = (tx_buf_empty || tx_shift_empty) ? 1 : 0;
      cand = -1;
      if (((ts && !m_txm) || m_txe) != 0) cand = 3;
      if (((rx_ready && !m_rxm) || m_rxe) != 0) cand = 2;
      if (ts && m_txm) cand = 1;
      if (rx_ready && m_rxm) cand = 0;
      fire = (m_req && req_ack) ? 1 : 0;
      rxd = (fire && m_id == 0 && m_rxc > 0 && !rx_cnt_we) ? 1 : 0;
      txd = (fire && m_id == 1 && m_txc > 0 && !tx_cnt_we) ? 1 : 0;
      rxz = (rxd && m_rxc == 1) ? 1 : 0;
      txz = (txd && m_txc == 1) ? 1 : 0;
      if (m_lvl == 7 || fire) m_req = 0;
      else if (!m_req && cand >= 0) begin m_req = 1; m_id = cand; end
      if (rx_cnt_we) m_rxc = cnt_wdata; else m_rxc -= rxd;
      if (tx_cnt_we) m_txc = cnt_wdata; else m_txc -= txd;
      if (cfg_we) begin m_rxm = cfg_rx_dma; m_txm = cfg_tx_dma; m_lvl = cfg_level; end
      else begin if (rxz) m_rxm = 0; if (txz) m_txm = 0; end
      if (rxz) m_rxe = 1; else if (rx_eob_clr) m_rxe = 0;
      if (txz) m_txe = 1; else if (tx_eob_clr) m_txe = 0;
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      check("R6 request valid", req_valid, m_req);
      if (m_req) check((m_id % 2) ? "R3 R4 source id" : "R2 R4 source id", req_id, m_id);
      check("R5 level", req_level, m_lvl);
      check("R7 R9 rx mask", rx_dma_mask, m_rxm);
      check("R7 R9 tx mask", tx_dma_mask, m_txm);
      check("R8 rx end-of-block", rx_eob, m_rxe);
      check("R8 tx end-of-block", tx_eob, m_txe);
    end
    if (ack_mode == 1) req_ack <= req_valid;
    else if (ack_mode == 2) req_ack <= $urandom_range(1, 0);
    else req_ack <= 1'b0;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(bit rxm, bit txm, int lvl);
    cfg_we = 1; cfg_rx_dma = rxm; cfg_tx_dma = txm; cfg_level = 3'(lvl);
    tick(1);
    cfg_we = 0;
  endtask

  task automatic load_cnt(bit rx, int v);
    cnt_wdata = CNT_W'(v);
    if (rx) rx_cnt_we = 1; else tx_cnt_we = 1;
    tick(1);
    rx_cnt_we = 0; tx_cnt_we = 0;
  endtask

  task automatic clr_eob();
    rx_eob_clr = 1; tx_eob_clr = 1;
    tick(1);
    rx_eob_clr = 0; tx_eob_clr = 0;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    // R1: reset state seen at the ports
    check("R1 valid", req_valid, 0);
    check("R1 level", req_level, 7);
    check("R1 masks", {rx_dma_mask, tx_dma_mask}, 0);
    check("R1 flags", {rx_eob, tx_eob}, 0);
    run_cmp = 1;
    rx_ready = 1; tick(4);                       // level 7: nothing (R5)
    // R2 R7: receive DMA stream ends after 3 transfers, then interrupts
    load_cnt(1, 3);
    wr_cfg(1, 0, 3);
    ack_mode = 1; tick(20);
    clr_eob(); tick(4);
    // R3: transmit via shift-empty, then buffer-empty
    rx_ready = 0; tx_shift_empty = 1; load_cnt(0, 2);
    wr_cfg(0, 1, 1); tick(12);
    tx_shift_empty = 0; tx_buf_empty = 1; tick(6);
    clr_eob();
    // R4: every source at once under each mask setting
    rx_ready = 1; tx_shift_empty = 1;
    load_cnt(1, 5); load_cnt(0, 5);
    wr_cfg(1, 1, 0); tick(30);
    wr_cfg(0, 1, 2); tick(8);
    wr_cfg(0, 0, 2); tick(8);
    // R6: hold without ack, sources withdrawn
    ack_mode = 0; tick(2);
    rx_ready = 0; tx_shift_empty = 0; tx_buf_empty = 0; tick(6);
    ack_mode = 1; tick(4);
    // R9: config write on the ack edge of the last transfer
    rx_ready = 1; clr_eob(); load_cnt(1, 1); wr_cfg(1, 0, 4);
    while (!req_valid) tick(1);
    wr_cfg(1, 0, 4); tick(4);
    load_cnt(1, 1); wr_cfg(1, 0, 4);
    while (!req_valid) tick(1);
    load_cnt(1, 6); tick(6);
    // R8: set and clear in the same cycle
    load_cnt(1, 1); wr_cfg(1, 0, 4);
    while (!req_valid) tick(1);
    rx_eob_clr = 1; tick(1); rx_eob_clr = 0; tick(3);
    // R5: level 7 silences the port while sources remain
    wr_cfg(1, 1, 7); tick(8);
    // random mix
    ack_mode = 2;
    for (int i = 0; i < 4000; i++) begin
      rx_ready = $urandom_range(1, 0);
      tx_buf_empty = $urandom_range(1, 0);
      tx_shift_empty = ($urandom_range(3, 0) == 0);
      cfg_we = ($urandom_range(15, 0) == 0);
      cfg_rx_dma = $urandom_range(1, 0);
      cfg_tx_dma = $urandom_range(1, 0);
      cfg_level = 3'($urandom_range(7, 0));
      rx_cnt_we = ($urandom_range(11, 0) == 0);
      tx_cnt_we = ($urandom_range(11, 0) == 0);
      cnt_wdata = CNT_W'($urandom_range(4, 0));
      rx_eob_clr = ($urandom_range(7, 0) == 0);
      tx_eob_clr = ($urandom_range(7, 0) == 0);
      tick(1);
    end
    cfg_we = 0; rx_cnt_we = 0; tx_cnt_we = 0;
    tick(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R6: got cycle %0d expected below 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule